// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Core

This block keeps the per-vector interrupt bookkeeping for a small processor. Each vector has an enable bit, a pending bit and an active bit. Each vector also has a priority, where a numerically smaller value is more urgent. Vector 0 is reserved and never competes. Vectors 1 to 3 carry the fixed priorities -3, -2 and -1. Vectors 4 and up take an 8-bit priority written through a small configuration port. External line `n` drives vector `16+n`.

The core keeps a running choice of the most urgent vector that is both enabled and pending. It also tracks the urgency of the work already in progress: the smallest priority among the active vectors, with the subpriority bits cleared according to a 3-bit grouping control. It raises one request toward the CPU when the pending choice would preempt that in-progress level.

The CPU takes the request with an acknowledge pulse. It ends a handler with a completion pulse that names the vector. The core answers each completion with an error flag or a flag that tells whether only one handler was running. When a handler for an external line completes while that line is still high, the core pends the vector again.

Top module: `irqarb_core`

## Requirements
- R1: After reset, `irq_req`=0, `pend_vec`=0, `pend_prio`=0x100, `act_prio`=0x100 and `exc_num`=0. Vectors 1, 2 and 3 hold priorities -3, -2 and -1. Only vectors 2, 3, 11, 12, 14 and 15 are enabled; vector 1 is disabled.
- R2: `pend_vec`/`pend_prio` name the enabled and pending vector with the smallest signed priority. Vector 0 is excluded. On a tie, the lower vector number wins. With no candidate, they read 0 and 0x100.
- R3: `act_prio` is the smallest priority among active vectors ANDed with (all-ones << (`prigroup`+1)) on a 10-bit signed value. It reads 0x100 when nothing is active.
- R4: `irq_req` is 1 exactly when `pend_prio` < `act_prio` (signed, strict). The arbitration outputs follow a state change one clock later, so an operation presented in cycle k shows in the outputs after the edge that ends cycle k+1.
- R5: `ack_valid` acts only when `irq_req` is 1 and the vector in `pend_vec` is still enabled and pending. It then sets that vector active, clears its pending bit and loads `exc_num` with it on the same edge. Any other acknowledge is ignored, including the one in the cycle right after a taken acknowledge.
- R6: `cmp_valid` with `cmp_vec` gives `cmp_done`=1 on the next cycle. If that vector is not active: `cmp_err`=1, `cmp_base`=0, no state change. Otherwise: `cmp_err`=0, `cmp_base`=1 if at most one vector was active before the clear and 0 if two or more were, and the active bit is cleared.
- R7: External line n pends vector 16+n only on a 0→1 transition. A line held high does not pend again after its pending bit is cleared.
- R8: Completing vector 16+n while line n is high sets that vector pending again.
- R9: The configuration operation codes are 0 enable-set, 1 enable-clear, 2 pend-set, 3 pend-clear and 4 priority-write. Any operation on vector 0 or on a vector number at or above the vector count is ignored. Enable and priority writes to vectors 1 to 3 are ignored. Pend-set and pend-clear on vectors 1 to 3 take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_line | input | NUM_EXT | External interrupt line levels |
| prigroup | input | 3 | Group/subpriority split point |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_op | input | 3 | Operation code (see R9) |
| cfg_vec | input | VW | Target vector number |
| cfg_prio | input | 8 | Priority value for a priority write |
| ack_valid | input | 1 | CPU takes the requested vector |
| cmp_valid | input | 1 | CPU finishes a handler |
| cmp_vec | input | VW | Vector whose handler finished |
| irq_req | output | 1 | Preemption request to the CPU |
| pend_vec | output | VW | Current pending winner (0 when none) |
| pend_prio | output | 10 | Signed priority of the winner, 0x100 when none |
| act_prio | output | 10 | Signed group priority of active work |
| exc_num | output | VW | Vector most recently acknowledged |
| cmp_done | output | 1 | Completion response valid |
| cmp_err | output | 1 | Completion named an inactive vector |
| cmp_base | output | 1 | At most one handler was active at completion |

## Verification
A corrupted enable, pending or active bit shows up at the ports one cycle after the state register settles: `pend_vec`, `pend_prio` or `act_prio` reads wrong. `irq_req` then leans the wrong way on the strict comparison. A wrong grouping mask shows only while some vector is active. The grouping sweep therefore holds an active vector, with a pending vector whose priority differs from it only in low bits, and walks all eight settings. Re-pend and single-active faults appear in the completion response and in the winner two cycles after the completion pulse.

// File: rtl/irqarb_pkg.sv
// Shared types and helpers for the interrupt arbitration core.
// Assumes priorities fit a 10-bit signed value: -3..255 plus the idle 0x100.
package irqarb_pkg;
    localparam int PRIO_W    = 10;
    localparam int FIRST_EXT = 16;
    localparam int NUM_FIXED = 3;

    typedef logic signed [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_IDLE = prio_t'(256);

    typedef enum logic [2:0] {
        OP_EN_SET   = 3'd0,
        OP_EN_CLR   = 3'd1,
        OP_PEND_SET = 3'd2,
        OP_PEND_CLR = 3'd3,
        OP_PRIO_WR  = 3'd4
    } cfg_op_e;

    // Mask that keeps only the group field of a priority
    function automatic prio_t group_mask(input logic [2:0] pg);
        logic [PRIO_W-1:0] m;
        m = '1;
        m = m << (int'(pg) + 1);
        return prio_t'(m);
    endfunction
endpackage

// File: rtl/irqarb_edge.sv
// Registers the external line levels and flags 0->1 transitions.
// Assumes the lines are already synchronous to clk.
module irqarb_edge #(
    parameter int NUM_EXT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] line_i,
    output logic [NUM_EXT-1:0] rise_o,
    output logic [NUM_EXT-1:0] level_o
);
    logic [NUM_EXT-1:0] lvl_q;

    // Hold the previous level of every line
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= line_i;
    end

    assign rise_o  = line_i & ~lvl_q;
    assign level_o = lvl_q;
endmodule

// File: rtl/irqarb_vec_bank.sv
// Per-vector enable, pending, active and priority storage.
// Vector 0 is tied off. Vectors 1..3 have constant priorities and
// enables. Inputs are per-vector one-hot set/clear requests; for a
// vector that gets a set and a clear in the same cycle, the set wins.
module irqarb_vec_bank
    import irqarb_pkg::*;
#(
    parameter int NUM_VEC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] en_set,
    input  logic [NUM_VEC-1:0] en_clr,
    input  logic [NUM_VEC-1:0] pend_set,
    input  logic [NUM_VEC-1:0] pend_clr,
    input  logic [NUM_VEC-1:0] act_set,
    input  logic [NUM_VEC-1:0] act_clr,
    input  logic [NUM_VEC-1:0] prio_we,
    input  logic [7:0]         prio_wdata,
    output logic [NUM_VEC-1:0] en_o,
    output logic [NUM_VEC-1:0] pend_o,
    output logic [NUM_VEC-1:0] act_o,
    output prio_t              prio_o [NUM_VEC]
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        if (v == 0) begin : g_unused
            assign en_o[v]   = 1'b0;
            assign pend_o[v] = 1'b0;
            assign act_o[v]  = 1'b0;
            assign prio_o[v] = PRIO_IDLE;
        end else begin : g_live
            logic pend_q, act_q;

            // Pending and active bits, set over clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                    act_q  <= 1'b0;
                end else begin
                    pend_q <= (pend_q & ~pend_clr[v]) | pend_set[v];
                    act_q  <= (act_q & ~act_clr[v]) | act_set[v];
                end
            end
            assign pend_o[v] = pend_q;
            assign act_o[v]  = act_q;

            if (v <= NUM_FIXED) begin : g_fixed
                assign en_o[v]   = (v != 1);
                assign prio_o[v] = prio_t'(v - 4);
            end else begin : g_prog
                localparam logic EN_RST = (v == 11) || (v == 12) || (v == 14) || (v == 15);
                logic       en_q;
                logic [7:0] prio_q;

                // Programmable enable and priority
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        en_q   <= EN_RST;
                        prio_q <= '0;
                    end else begin
                        en_q <= (en_q & ~en_clr[v]) | en_set[v];
                        if (prio_we[v]) prio_q <= prio_wdata;
                    end
                end
                assign en_o[v]   = en_q;
                assign prio_o[v] = prio_t'({2'b00, prio_q});
            end
        end
    end
endmodule

// File: rtl/irqarb_select.sv
// Chooses the most urgent enabled+pending vector and the group priority
// of active vectors, then registers both along with the request.
// Ties resolve to the lower vector because only a strictly smaller
// priority replaces the running candidate.
module irqarb_select
    import irqarb_pkg::*;
#(
    parameter int NUM_VEC = 24,
    parameter int VW      = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] en_i,
    input  logic [NUM_VEC-1:0] pend_i,
    input  logic [NUM_VEC-1:0] act_i,
    input  prio_t              prio_i [NUM_VEC],
    input  logic [2:0]         prigroup,
    output logic [VW-1:0]      win_vec_q,
    output prio_t              win_prio_q,
    output prio_t              act_prio_q,
    output logic               req_q
);
    logic [VW-1:0] best_v;
    prio_t         best_p;
    prio_t         act_min;
    prio_t         act_grp;

    // Linear priority scan over vectors 1..NUM_VEC-1
    always_comb begin
        best_v  = '0;
        best_p  = PRIO_IDLE;
        act_min = PRIO_IDLE;
        for (int v = 1; v < NUM_VEC; v++) begin
            if (en_i[v] && pend_i[v] && (prio_i[v] < best_p)) begin
                best_p = prio_i[v];
                best_v = VW'(v);
            end
            if (act_i[v] && (prio_i[v] < act_min)) begin
                act_min = prio_i[v];
            end
        end
        act_grp = act_min & group_mask(prigroup);
    end

    // Register the arbitration result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vec_q  <= '0;
            win_prio_q <= PRIO_IDLE;
            act_prio_q <= PRIO_IDLE;
            req_q      <= 1'b0;
        end else begin
            win_vec_q  <= best_v;
            win_prio_q <= best_p;
            act_prio_q <= act_grp;
            req_q      <= (best_p < act_grp);
        end
    end
endmodule

// File: rtl/irqarb_core.sv
// Top of the interrupt arbitration core. Decodes configuration,
// acknowledge and completion into per-vector set/clear requests,
// and answers completions one cycle later.
// Assumes: ack_valid is only meaningful while irq_req is high; an
// acknowledge in the cycle right after a taken one sees a stale
// winner and is dropped.
module irqarb_core
    import irqarb_pkg::*;
#(
    parameter int NUM_EXT = 8,
    localparam int NUM_VEC = FIRST_EXT + NUM_EXT,
    localparam int VW      = $clog2(NUM_VEC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EXT-1:0]       ext_line,
    input  logic [2:0]               prigroup,
    input  logic                     cfg_valid,
    input  logic [2:0]               cfg_op,
    input  logic [VW-1:0]            cfg_vec,
    input  logic [7:0]               cfg_prio,
    input  logic                     ack_valid,
    input  logic                     cmp_valid,
    input  logic [VW-1:0]            cmp_vec,
    output logic                     irq_req,
    output logic [VW-1:0]            pend_vec,
    output logic signed [PRIO_W-1:0] pend_prio,
    output logic signed [PRIO_W-1:0] act_prio,
    output logic [VW-1:0]            exc_num,
    output logic                     cmp_done,
    output logic                     cmp_err,
    output logic                     cmp_base
);
    logic [NUM_EXT-1:0] rise, level;
    logic [NUM_VEC-1:0] en, pend, act;
    prio_t              prio [NUM_VEC];
    logic [NUM_VEC-1:0] en_set, en_clr, pend_set, pend_clr, act_set, act_clr, prio_we;
    logic [VW-1:0]      win_vec;
    prio_t              win_prio, act_grp;
    logic               req;
    logic               ack_go, cmp_hit;
    cfg_op_e            op;
    logic [VW-1:0]      exc_q;
    logic               done_q, err_q, base_q;

    irqarb_edge #(.NUM_EXT(NUM_EXT)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (ext_line),
        .rise_o  (rise),
        .level_o (level)
    );

    assign op = cfg_op_e'(cfg_op);

    // Turn all request sources into per-vector set/clear strobes
    always_comb begin
        ack_go   = 1'b0;
        cmp_hit  = 1'b0;
        en_set   = '0;
        en_clr   = '0;
        pend_set = '0;
        pend_clr = '0;
        act_set  = '0;
        act_clr  = '0;
        prio_we  = '0;
        for (int v = 1; v < NUM_VEC; v++) begin
            if (ack_valid && req && (win_vec == VW'(v)) && en[v] && pend[v]) ack_go = 1'b1;
            if (cmp_valid && (cmp_vec == VW'(v)) && act[v]) cmp_hit = 1'b1;
        end
        for (int v = 1; v < NUM_VEC; v++) begin
            logic sel, prog, win_here, cmp_here;
            sel      = cfg_valid && (cfg_vec == VW'(v));
            prog     = sel && (v > NUM_FIXED);
            win_here = ack_go && (win_vec == VW'(v));
            cmp_here = cmp_hit && (cmp_vec == VW'(v));
            en_set[v]   = prog && (op == OP_EN_SET);
            en_clr[v]   = prog && (op == OP_EN_CLR);
            prio_we[v]  = prog && (op == OP_PRIO_WR);
            pend_set[v] = sel && (op == OP_PEND_SET);
            pend_clr[v] = (sel && (op == OP_PEND_CLR)) || win_here;
            act_set[v]  = win_here;
            act_clr[v]  = cmp_here;
            if (v >= FIRST_EXT) begin
                if (rise[v-FIRST_EXT]) pend_set[v] = 1'b1;
                if (cmp_here && level[v-FIRST_EXT]) pend_set[v] = 1'b1;
            end
        end
    end

    irqarb_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .pend_set   (pend_set),
        .pend_clr   (pend_clr),
        .act_set    (act_set),
        .act_clr    (act_clr),
        .prio_we    (prio_we),
        .prio_wdata (cfg_prio),
        .en_o       (en),
        .pend_o     (pend),
        .act_o      (act),
        .prio_o     (prio)
    );

    irqarb_select #(.NUM_VEC(NUM_VEC), .VW(VW)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .pend_i     (pend),
        .act_i      (act),
        .prio_i     (prio),
        .prigroup   (prigroup),
        .win_vec_q  (win_vec),
        .win_prio_q (win_prio),
        .act_prio_q (act_grp),
        .req_q      (req)
    );

    // Executing vector and completion response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            base_q <= 1'b0;
        end else begin
            if (ack_go) exc_q <= win_vec;
            done_q <= cmp_valid;
            err_q  <= cmp_valid && !cmp_hit;
            base_q <= cmp_hit && ($countones(act) <= 1);
        end
    end

    assign irq_req   = req;
    assign pend_vec  = win_vec;
    assign pend_prio = win_prio;
    assign act_prio  = act_grp;
    assign exc_num   = exc_q;
    assign cmp_done  = done_q;
    assign cmp_err   = err_q;
    assign cmp_base  = base_q;
endmodule

// File: rtl/irqarb_core_chk.sv
// Port-level properties of the arbitration core, bound into it.
module irqarb_core_chk #(
    parameter int NUM_EXT = 8,
    parameter int VW      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_valid,
    input logic              cmp_valid,
    input logic              irq_req,
    input logic [VW-1:0]     pend_vec,
    input logic signed [9:0] pend_prio,
    input logic signed [9:0] act_prio,
    input logic [VW-1:0]     exc_num,
    input logic              cmp_done,
    input logic              cmp_err,
    input logic              cmp_base
);
    p_req_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_prio < act_prio));

    p_req_has_winner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_vec != '0));

    p_idle_sentinel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0) |-> (pend_prio == 10'sd256));

    p_exc_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exc_num) |-> $past(ack_valid && irq_req));

    p_cmp_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> cmp_done);

    p_cmp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !cmp_done);

    p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |-> (cmp_done && !cmp_base));
endmodule

bind irqarb_core irqarb_core_chk #(.NUM_EXT(NUM_EXT), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .cmp_valid (cmp_valid),
    .irq_req   (irq_req),
    .pend_vec  (pend_vec),
    .pend_prio (pend_prio),
    .act_prio  (act_prio),
    .exc_num   (exc_num),
    .cmp_done  (cmp_done),
    .cmp_err   (cmp_err),
    .cmp_base  (cmp_base)
);

// File: tb/irqarb_core_tb.sv
`timescale 1ns/1ps
module irqarb_core_tb;
    localparam int NEXT = 8;
    localparam int NV   = 16 + NEXT;
    localparam int VW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NEXT-1:0] ext_line = '0;
    logic [2:0] prigroup = 3'd0;
    logic cfg_valid = 1'b0;
    logic [2:0] cfg_op = '0;
    logic [VW-1:0] cfg_vec = '0;
    logic [7:0] cfg_prio = '0;
    logic ack_valid = 1'b0;
    logic cmp_valid = 1'b0;
    logic [VW-1:0] cmp_vec = '0;
    logic irq_req;
    logic [VW-1:0] pend_vec, exc_num;
    logic signed [9:0] pend_prio, act_prio;
    logic cmp_done, cmp_err, cmp_base;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side model of the vector state
    int m_en [NV];
    int m_pend [NV];
    int m_act [NV];
    int m_prio [NV];
    int m_exc = 0;

    always #4 clk = ~clk;

    irqarb_core #(.NUM_EXT(NEXT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .prigroup(prigroup),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_vec(cfg_vec), .cfg_prio(cfg_prio),
        .ack_valid(ack_valid), .cmp_valid(cmp_valid), .cmp_vec(cmp_vec),
        .irq_req(irq_req), .pend_vec(pend_vec), .pend_prio(pend_prio), .act_prio(act_prio),
        .exc_num(exc_num), .cmp_done(cmp_done), .cmp_err(cmp_err), .cmp_base(cmp_base)
    );

    task automatic chk(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    function automatic int e_win();
        int bp = 256, bv = 0;
        for (int v = 1; v < NV; v++)
            if (m_en[v] != 0 && m_pend[v] != 0 && m_prio[v] < bp) begin bp = m_prio[v]; bv = v; end
        return bv;
    endfunction

    function automatic int e_pprio();
        int w = e_win();
        return (w == 0) ? 256 : m_prio[w];
    endfunction

    function automatic int e_aprio();
        int a = 256;
        for (int v = 1; v < NV; v++)
            if (m_act[v] != 0 && m_prio[v] < a) a = m_prio[v];
        return a & ((-1) <<< (int'(prigroup) + 1));
    endfunction

    function automatic int n_active();
        int c = 0;
        for (int v = 1; v < NV; v++) c += m_act[v];
        return c;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " pend_vec"}, int'(pend_vec), e_win());
        chk({tag, " pend_prio"}, int'(pend_prio), e_pprio());
        chk({tag, " act_prio"}, int'(act_prio), e_aprio());
        chk({tag, " irq_req"}, int'(irq_req), (e_pprio() < e_aprio()) ? 1 : 0);
    endtask

    task automatic cfg(input int op, input int vec, input int pr, input string tag);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = 3'(op); cfg_vec = VW'(vec); cfg_prio = 8'(pr);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (vec > 0 && vec < NV) begin
            if (vec > 3 && op == 0) m_en[vec] = 1;
            if (vec > 3 && op == 1) m_en[vec] = 0;
            if (op == 2) m_pend[vec] = 1;
            if (op == 3) m_pend[vec] = 0;
            if (vec > 3 && op == 4) m_prio[vec] = pr;
        end
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic line(input int n, input logic val, input string tag);
        @(negedge clk);
        if (val && !ext_line[n]) m_pend[16+n] = 1;
        ext_line[n] = val;
        @(negedge clk);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic ack(input string tag);
        int w;
        w = e_win();
        @(negedge clk);
        ack_valid = 1'b1;
        if (e_pprio() < e_aprio()) begin m_act[w] = 1; m_pend[w] = 0; m_exc = w; end
        @(negedge clk);
        ack_valid = 1'b0;
        chk({tag, " exc_num"}, int'(exc_num), m_exc);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic ack_twice(input string tag);
        int w;
        w = e_win();
        @(negedge clk);
        ack_valid = 1'b1;
        if (e_pprio() < e_aprio()) begin m_act[w] = 1; m_pend[w] = 0; m_exc = w; end
        @(negedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
        chk({tag, " exc_num"}, int'(exc_num), m_exc);
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic complete(input int v, input string tag);
        int e_err, e_base;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_vec = VW'(v);
        e_err = (m_act[v] == 0) ? 1 : 0;
        e_base = (e_err == 0 && n_active() <= 1) ? 1 : 0;
        if (e_err == 0) begin
            m_act[v] = 0;
            if (v >= 16 && ext_line[v-16]) m_pend[v] = 1;
        end
        @(negedge clk);
        cmp_valid = 1'b0;
        chk({tag, " cmp_done"}, int'(cmp_done), 1);
        chk({tag, " cmp_err"}, int'(cmp_err), e_err);
        chk({tag, " cmp_base"}, int'(cmp_base), e_base);
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            m_en[v] = (v == 2 || v == 3 || v == 11 || v == 12 || v == 14 || v == 15) ? 1 : 0;
            m_pend[v] = 0; m_act[v] = 0;
            m_prio[v] = (v >= 1 && v <= 3) ? v - 4 : 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check_state("R1");
        chk("R1 exc_num", int'(exc_num), 0);
        chk("R1 cmp_done", int'(cmp_done), 0);
        // R1: vector 1 disabled, vector 2 enabled at reset
        cfg(2, 1, 0, "R1 vec1 disabled");
        cfg(2, 2, 0, "R1 vec2 enabled prio -2");
        cfg(3, 2, 0, "R9 pend-clear fixed vector");
        cfg(3, 1, 0, "R9 pend-clear vec1");

        // R9: program vector 16
        cfg(0, 16, 0, "R9 enable 16");
        cfg(4, 16, 8'h40, "R9 prio 16");
        // R7: rising edge pends vector 16
        line(0, 1'b1, "R7 rise pends 16");
        // R2: equal priority tie goes to lower number
        cfg(0, 17, 0, "R9 enable 17");
        cfg(4, 17, 8'h40, "R9 prio 17");
        cfg(2, 17, 0, "R2 tie lower vector");
        // R9: vector 0 is ignored
        cfg(2, 0, 0, "R9 vec0 ignored");
        // R5/R4: ack 16; 17 equal prio does not preempt
        ack("R5 ack 16");
        chk("R4 no preempt on equal", int'(irq_req), 0);

        // R3: sweep the grouping control with 18 at 0x20 pending
        cfg(0, 18, 0, "R9 enable 18");
        cfg(4, 18, 8'h20, "R9 prio 18");
        cfg(2, 18, 0, "R4 preempt request");
        for (int pg = 0; pg < 8; pg++) begin
            @(negedge clk);
            prigroup = 3'(pg);
            @(negedge clk);
            @(negedge clk);
            check_state("R3 prigroup sweep");
        end
        @(negedge clk);
        prigroup = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check_state("R3 back to 0");

        ack("R5 ack 18");
        // R8: line 0 still high; two active -> base 0
        complete(16, "R8 repend on complete");
        complete(16, "R6 inactive complete");
        complete(18, "R6 single active");

        // R2: fixed vector 2 wins at -2; R9 prio write ignored
        cfg(2, 2, 0, "R2 NMI wins");
        cfg(4, 2, 8'h80, "R9 fixed prio ignored");
        ack("R5 ack 2");
        complete(2, "R6 complete 2");

        // R5: back-to-back acks take only one vector
        ack_twice("R5 back to back");
        complete(16, "R8 second repend");

        // R7: held-high line does not re-pend after clear
        cfg(3, 16, 0, "R7 clear while high");
        repeat (4) @(negedge clk);
        check_state("R7 no repend on level");
        line(0, 1'b0, "R7 line low");
        line(0, 1'b1, "R7 second rise");

        // R2: disabled vector is skipped
        cfg(1, 16, 0, "R2 disabled skipped");
        cfg(1, 17, 0, "R2 all disabled");
        cfg(0, 16, 0, "R2 reenable");
        cfg(4, 16, 8'hFF, "R9 prio 255");
        cfg(4, 30, 8'h01, "R9 out of range vec ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule